// File: doc/BRIEF.md
# CAN bit timer

This block divides a CAN controller clock into time quanta and arranges the quanta into bits. Each bit is laid out as a one-quantum synchronisation slot, then a pre-sample segment, then a post-sample segment. A single 16-bit timing word sets the layout. That word holds a prescaler value, an optional fixed divide-by-8 ahead of the prescaler, the two segment lengths and the resynchronisation jump limit. The block marks the transmit point at the start of every bit and the sample point at the boundary between the two segments. At the sample point it captures the receive line.

A falling edge on the receive line (recessive to dominant) that arrives late in the bit stretches the pre-sample segment. One that arrives early, after the sample point, trims the post-sample segment. Either correction is capped at the jump limit, and only one correction is made per bit. A hard-sync request forces a new bit to begin at the next quantum boundary. A new timing word is picked up only when a bit starts, so the bit in progress is never distorted. A bit-stream engine sits on top of the block and uses the two strobes to shift frames in and out.

Top module: `can_bit_timer`

## Requirements
- R1: `timing_cfg[5:0]` is the prescaler value BRP and `timing_cfg[15]` enables an extra divide by PRE_DIV (default 8). One time quantum lasts (BRP+1) clocks, times PRE_DIV when bit 15 is set. `tq_tick` is high for the last clock of each quantum, so the first tick of a bit is seen Q-1 clocks after that bit's `tx_stb`.
- R2: With no receive edges and no hard sync, a bit lasts (1 + (`timing_cfg[11:8]`+1) + (`timing_cfg[14:12]`+1)) quanta. That is the interval from one `tx_stb` pulse to the next.
- R3: `sample_stb` pulses (`timing_cfg[11:8]`+2) quanta after the `tx_stb` of the same bit, when no correction has occurred in the pre-sample segment.
- R4: `sample_bit` takes the value `rx_in` had in the clock before `sample_stb` rises. A falling edge during the synchronisation quantum causes no correction.
- R5: A falling edge seen during quantum k (counting from 0) of the pre-sample segment lengthens that segment by min(k+1, SJW+1) quanta. SJW is `timing_cfg[7:6]`.
- R6: A falling edge seen during quantum k of the post-sample segment, whose length is L2 = `timing_cfg[14:12]`+1, shortens it by min(L2-1-k, SJW+1) quanta.
- R7: Only the first falling edge after the synchronisation quantum of a bit is acted on. Rising edges (dominant 0 to recessive 1) never change the timing.
- R8: A one-clock `hsync_req` makes the next quantum a synchronisation quantum, whatever the current segment. `tx_stb` then appears at the next quantum boundary and no sample strobe is given for the abandoned bit.
- R9: A change of `timing_cfg` during a bit leaves that bit's length unchanged. The new value governs every bit that starts after it.
- R10: After reset `seg_state` is 0 (synchronisation; 1 is pre-sample, 2 is post-sample) and both strobes are low.
- R11: `sample_stb` and `tx_stb` are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CAN controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_cfg | input | 16 | Packed bit timing word |
| rx_in | input | 1 | Synchronised receive line, 1 recessive, 0 dominant |
| hsync_req | input | 1 | Request to restart the bit at the next quantum |
| tq_tick | output | 1 | High in the last clock of each time quantum |
| seg_state | output | 2 | Current segment: 0 sync, 1 pre-sample, 2 post-sample |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Receive value captured at the sample point |
| tx_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
The bench builds the block with its default PRE_DIV of 8. This makes the divided quantum reachable with small prescaler values, so divided bits stay a few hundred clocks long. Random timing words cover short quanta of one to four clocks and every segment length and jump limit, so the clipped and the unclipped branches of both corrections are reached. Directed bits cover the 16-quantum 500 kbit/s layout at 24 MHz, mid-bit word changes, hard sync in each segment, and a second falling edge after a correction.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRE_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] timing_cfg,
  input  logic        rx_in,
  input  logic        hsync_req,
  output logic        tq_tick,
  output logic [1:0]  seg_state,
  output logic        sample_stb,
  output logic        sample_bit,
  output logic        tx_stb
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int SEG_W = 5;
  localparam logic [1:0] ST_SYNC = 2'd0;
  localparam logic [1:0] ST_PRE  = 2'd1;
  localparam logic [1:0] ST_POST = 2'd2;

  logic [15:0]      cfg_q;
  logic [PRE_W-1:0] pre;
  logic [5:0]       qcnt;
  logic [1:0]       st;
  logic [SEG_W-1:0] cnt;
  logic [2:0]       ext, shr;
  logic             synced, hs_pend, rx_prev;

  wire       div_on = cfg_q[15];
  wire [2:0] t2     = cfg_q[14:12];
  wire [3:0] t1     = cfg_q[11:8];
  wire [2:0] sjw1   = {1'b0, cfg_q[7:6]} + 3'd1;
  wire [5:0] brp    = cfg_q[5:0];

  wire pre_en = !div_on || (pre == PRE_W'(PRE_DIV - 1));
  assign tq_tick = pre_en && (qcnt == brp);

  function automatic logic [2:0] clip(input logic [SEG_W-1:0] err, input logic [2:0] lim);
    return (err < SEG_W'(lim)) ? err[2:0] : lim;
  endfunction

  wire fall    = rx_prev && !rx_in;
  wire resync1 = fall && !synced && (st == ST_PRE);
  wire resync2 = fall && !synced && (st == ST_POST);

  wire [SEG_W-1:0] cnt_nx  = cnt + SEG_W'(1);
  wire [2:0]       ext_eff = resync1 ? clip(cnt_nx, sjw1) : ext;
  wire [2:0]       shr_eff = resync2 ? clip(SEG_W'(t2) - cnt, sjw1) : shr;
  wire [SEG_W-1:0] len1    = SEG_W'(t1) + SEG_W'(1) + SEG_W'(ext_eff);
  wire [SEG_W-1:0] len2    = SEG_W'(t2) + SEG_W'(1) - SEG_W'(shr_eff);
  wire             last_q  = cnt_nx >= ((st == ST_PRE) ? len1 : len2);
  wire             restart = tq_tick && (hs_pend || hsync_req || ((st == ST_POST) && last_q));

  assign seg_state = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      qcnt <= '0;
    end else if (tq_tick) begin
      pre  <= '0;
      qcnt <= '0;
    end else begin
      if (div_on) pre <= pre + PRE_W'(1);
      if (pre_en) qcnt <= qcnt + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= timing_cfg;
      st         <= ST_SYNC;
      cnt        <= '0;
      ext        <= '0;
      shr        <= '0;
      synced     <= 1'b0;
      hs_pend    <= 1'b0;
      rx_prev    <= 1'b1;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      tx_stb     <= 1'b0;
    end else begin
      rx_prev    <= rx_in;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      hs_pend    <= tq_tick ? 1'b0 : (hs_pend || hsync_req);
      if (resync1) begin
        ext    <= ext_eff;
        synced <= 1'b1;
      end
      if (resync2) begin
        shr    <= shr_eff;
        synced <= 1'b1;
      end
      if (restart) begin
        st     <= ST_SYNC;
        cnt    <= '0;
        ext    <= '0;
        shr    <= '0;
        synced <= 1'b0;
        cfg_q  <= timing_cfg;
        tx_stb <= 1'b1;
      end else if (tq_tick) begin
        if (st == ST_SYNC) begin
          st  <= ST_PRE;
          cnt <= '0;
        end else if ((st == ST_PRE) && last_q) begin
          st         <= ST_POST;
          cnt        <= '0;
          sample_stb <= 1'b1;
          sample_bit <= rx_in;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  a_r2_tx_opens_sync: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> (st == ST_SYNC) && (cnt == '0));

  a_r3_sample_opens_post: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (st == ST_POST) && (cnt == '0));

  a_r4_sample_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_stb) |-> (sample_bit == $past(rx_in)));

  a_r5_pre_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |-> (cnt < len1) && (ext <= sjw1));

  a_r6_post_trim_limited: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POST) |-> (shr <= sjw1) && (SEG_W'(shr) <= SEG_W'(t2)));

  a_r8_hsync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && hsync_req) |=> tx_stb);

  a_r9_cfg_at_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(cfg_q)) |-> tx_stb);

endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg = 16'h6702;
  logic rx = 1'b1;
  logic hs = 1'b0;
  logic tq_tick, sample_stb, sample_bit, tx_stb;
  logic [1:0] seg_state;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .timing_cfg(cfg), .rx_in(rx), .hsync_req(hs),
    .tq_tick(tq_tick), .seg_state(seg_state), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .tx_stb(tx_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int qlen(input logic [15:0] c);
    return (int'(c[5:0]) + 1) * (c[15] ? 8 : 1);
  endfunction
  function automatic int len1(input logic [15:0] c); return int'(c[11:8]) + 1; endfunction
  function automatic int len2(input logic [15:0] c); return int'(c[14:12]) + 1; endfunction
  function automatic int sjw1(input logic [15:0] c); return int'(c[7:6]) + 1; endfunction
  function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction

  task automatic run_bit(input int drop_at, input int rise_at, input int drop2_at, input int hs_at,
                         input int cfg_at, input logic [15:0] cfg_new,
                         output int smp, output int per, output int ftick, output logic sbit);
    smp = -1; per = -1; ftick = -1; sbit = 1'b1;
    for (int n = 0; n < 30000; n++) begin
      if (n > 0) @(negedge clk);
      if (n > 0 && sample_stb && smp < 0) begin
        smp = n;
        sbit = sample_bit;
      end
      if (tq_tick && ftick < 0) ftick = n;
      if (n > 0 && tx_stb) begin
        per = n;
        break;
      end
      if (n == drop_at) rx = 1'b0;
      if (n == rise_at) rx = 1'b1;
      if (n == drop2_at) rx = 1'b0;
      hs = (n == hs_at);
      if (n == cfg_at) cfg = cfg_new;
    end
    rx = 1'b1;
    hs = 1'b0;
  endtask

  task automatic align(input logic [15:0] c);
    int s, p, f;
    logic b;
    run_bit(-1, -1, -1, -1, 0, c, s, p, f, b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL all watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int s, p, f, q, l1, l2, sj, k, e;
    logic b;
    logic [15:0] c;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R10 seg_state", int'(seg_state), 0);
    chk("R10 tx_stb", int'(tx_stb), 0);
    chk("R10 sample_stb", int'(sample_stb), 0);

    run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
    run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
    chk("R2 500k bit clocks", p, 48);
    chk("R3 500k sample clocks", s, 27);
    chk("R1 first tick", f, 2);
    chk("R11 sample count per bit", (s > 0 && s < p) ? 1 : 0, 1);

    run_bit(-1, -1, -1, -1, 5, 16'hE702, s, p, f, b);
    chk("R9 old word keeps bit", p, 48);
    run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
    chk("R1 divided first tick", f, 23);
    chk("R2 divided bit clocks", p, 384);
    chk("R3 divided sample clocks", s, 216);

    align(16'h67C2);
    run_bit(0, -1, -1, -1, -1, cfg, s, p, f, b);
    chk("R4 sample of dominant", int'(b), 0);
    chk("R4 sync edge no shift", s, 27);
    run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
    chk("R4 sample of recessive", int'(b), 1);
    chk("R7 rising edge ignored", p, 48);

    run_bit(3, 9, 18, -1, -1, cfg, s, p, f, b);
    chk("R7 second edge ignored sample", s, 30);
    chk("R7 second edge ignored period", p, 51);

    run_bit(-1, -1, -1, 13, -1, cfg, s, p, f, b);
    chk("R8 hard sync in pre-sample", p, 15);
    chk("R8 no sample on restart", s, -1);
    run_bit(-1, -1, -1, 34, -1, cfg, s, p, f, b);
    chk("R8 hard sync in post-sample", p, 36);
    run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
    chk("R8 normal bit after restart", p, 48);

    for (int it = 0; it < 24; it++) begin
      logic dv;
      dv = (($urandom % 6) == 0);
      c[15]    = dv;
      c[14:12] = 3'($urandom % 8);
      c[11:8]  = 4'($urandom % 16);
      c[7:6]   = 2'($urandom % 4);
      c[5:0]   = dv ? 6'($urandom % 2) : 6'($urandom % 4);
      q = qlen(c); l1 = len1(c); l2 = len2(c); sj = sjw1(c);
      align(c);
      run_bit(-1, -1, -1, -1, -1, cfg, s, p, f, b);
      chk("R1 random first tick", f, q - 1);
      chk("R2 random bit clocks", p, q * (1 + l1 + l2));
      chk("R3 random sample clocks", s, q * (1 + l1));

      k = int'($urandom % l1);
      e = imin(k + 1, sj);
      run_bit(q * (1 + k), -1, -1, -1, -1, cfg, s, p, f, b);
      chk("R5 lengthened sample", s, q * (1 + l1 + e));
      chk("R5 lengthened bit", p, q * (1 + l1 + e + l2));

      k = int'($urandom % l2);
      e = imin(l2 - 1 - k, sj);
      run_bit(q * (1 + l1 + k), -1, -1, -1, -1, cfg, s, p, f, b);
      chk("R6 sample unchanged", s, q * (1 + l1));
      chk("R6 shortened bit", p, q * (1 + l1 + l2 - e));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule